// File: doc/BRIEF.md
# Gain-Scheduled PI Duty Controller with Integrator Preset

This block is the sampled current loop of a bidirectional half-bridge converter whose switches carry a dead time that is large compared with the switching period. On every sample strobe it takes a current set-point, a measured current and a feed-forward duty. It computes a signed correction `delta` with a PI law and returns the regulated duty, which is the feed-forward duty plus `delta`, held within 0 to 1.0. A flag reports which of the two gain sets produced the result.

Near zero current, conduction is discontinuous and the current hardly reacts to the duty. Above the boundary, conduction is continuous and the current reacts very strongly. The block therefore applies fast gains when the set-point magnitude is below a boundary and mild gains at or above it. When the set-point jumps into the other region, it overwrites the integrator with a signed dead-time offset, so the loop starts next to its new equilibrium and does not have to integrate across the whole dead band. The previous `delta` tells the block which region it is in now.

Currents are signed with 4 fractional bits (1 LSB = 1/16 A). Duties are Q.16, so 1.0 = 65536.

Top module: `dtc_pi_sched`

## Requirements
- R1: `duty_reg` = clamp(`duty_ff` + delta, 0, 65536), with delta = integ + floor(err*KP/256).
- R2: `duty_valid` pulses exactly two clock cycles after each `smp_valid`. Without a strobe, no output pulse appears, and neither `duty_reg` nor the internal state changes.
- R3: err = `iref` - `imeas`. On each sample the integrator becomes clamp(integ + floor(err*KI/256)) unless a preset applies.
- R4: The mild gains (KP 472, KI 42) are used and `mild_gains` = 1 when |`iref`| >= 112 (7 A). Otherwise the fast gains (KP 1573, KI 839) are used and `mild_gains` = 0.
- R5: The anti-windup limit on the integrator is ±10486 (Td/Tsw = 0.16) under the fast gains and ±(10486+655) under the mild gains.
- R6: The integrator is preset to +10486 when the set-point is large and positive and the previous delta is not above +10486. It is preset to -10486 when the set-point is large and negative and the previous delta is not below -10486.
- R7: The integrator is preset to +5243 when the set-point is small and non-negative and the previous delta lies outside ±10486. It is preset to -5243 when the set-point is small and negative under the same condition.
- R8: No preset fires unless |err| > 32 (2 A).
- R9: After reset, `duty_reg` = 0, `mild_gains` = 0, `duty_valid` = 0, and the integrator and delta are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| iref | input | 16 | Current set-point, signed, 1/16 A |
| imeas | input | 16 | Measured current, signed, 1/16 A |
| duty_ff | input | 17 | Feed-forward duty, Q.16 |
| duty_valid | output | 1 | New regulated duty present |
| duty_reg | output | 17 | Regulated duty, Q.16 |
| mild_gains | output | 1 | Mild gain set was used |

## Verification
The bench builds the block with its default parameters: a 0.16 dead-time ratio, a 7 A boundary, a 2 A preset threshold and gains scaled by 256. These values make each preset branch reachable within a few samples. The integrator reaches the mild anti-windup ceiling after about a dozen large-error samples. The set-points of exactly 112 and 111 LSB straddle the gain boundary. Feed-forward values near 0 and near 1.0 drive the output clamp at both ends.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int MW = 32;

  typedef struct packed {
    logic signed [MW-1:0] err;
    logic signed [MW-1:0] ff;
    logic                 ref_large;
    logic                 ref_neg;
    logic                 big_err;
  } samp_t;

  function automatic logic signed [MW-1:0] sat(input logic signed [MW-1:0] x,
                                              input logic signed [MW-1:0] lo,
                                              input logic signed [MW-1:0] hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction
endpackage

// File: rtl/dtc_err_stage.sv
module dtc_err_stage
  import dtc_pkg::*;
#(
  parameter int CW     = 16,
  parameter int DUTY_W = 17,
  parameter int BOUND  = 112,
  parameter int ERR_TH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [CW-1:0]     iref,
  input  logic signed [CW-1:0]     imeas,
  input  logic        [DUTY_W-1:0] duty_ff,
  output samp_t                    samp_q,
  output logic                     valid_q
);
  samp_t samp_d;
  logic signed [MW-1:0] ref_x, meas_x, err_x, ref_abs, err_abs;

  always_comb begin
    ref_x   = MW'(iref);
    meas_x  = MW'(imeas);
    err_x   = ref_x - meas_x;
    ref_abs = (ref_x < 0) ? -ref_x : ref_x;
    err_abs = (err_x < 0) ? -err_x : err_x;
    samp_d.err       = err_x;
    samp_d.ff        = MW'(duty_ff);
    samp_d.ref_large = (ref_abs >= MW'(BOUND));
    samp_d.ref_neg   = (ref_x < 0);
    samp_d.big_err   = (err_abs > MW'(ERR_TH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= smp_valid;
      if (smp_valid) samp_q <= samp_d;
    end
  end
endmodule

// File: rtl/dtc_preset_sel.sv
module dtc_preset_sel
  import dtc_pkg::*;
#(
  parameter int TD_RATIO     = 10486,
  parameter int SMALL_PRESET = 5243
) (
  input  samp_t                samp,
  input  logic signed [MW-1:0] delta_q,
  output logic                 pre_en,
  output logic signed [MW-1:0] pre_val
);
  logic st_lpos, st_lneg;

  always_comb begin
    st_lpos = (delta_q > MW'(TD_RATIO));
    st_lneg = (delta_q < -MW'(TD_RATIO));
    pre_en  = 1'b0;
    pre_val = '0;
    if (samp.big_err) begin
      if (samp.ref_large && !samp.ref_neg && !st_lpos) begin
        pre_en  = 1'b1;
        pre_val = MW'(TD_RATIO);
      end else if (samp.ref_large && samp.ref_neg && !st_lneg) begin
        pre_en  = 1'b1;
        pre_val = -MW'(TD_RATIO);
      end else if (!samp.ref_large && (st_lpos || st_lneg)) begin
        pre_en  = 1'b1;
        pre_val = samp.ref_neg ? -MW'(SMALL_PRESET) : MW'(SMALL_PRESET);
      end
    end
  end
endmodule

// File: rtl/dtc_pi_core.sv
module dtc_pi_core
  import dtc_pkg::*;
#(
  parameter int DUTY_W    = 17,
  parameter int FRAC      = 16,
  parameter int GSH       = 8,
  parameter int KP_FAST   = 1573,
  parameter int KI_FAST   = 839,
  parameter int KP_MILD   = 472,
  parameter int KI_MILD   = 42,
  parameter int TD_RATIO  = 10486,
  parameter int AW_MARGIN = 655
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_a,
  input  samp_t                    samp,
  input  logic                     pre_en,
  input  logic signed [MW-1:0]     pre_val,
  output logic signed [MW-1:0]     delta_q,
  output logic        [DUTY_W-1:0] duty_q,
  output logic                     mild_q,
  output logic                     valid_q
);
  localparam logic signed [MW-1:0] ONE    = MW'(1) <<< FRAC;
  localparam logic signed [MW-1:0] LIM_F  = MW'(TD_RATIO);
  localparam logic signed [MW-1:0] LIM_M  = MW'(TD_RATIO + AW_MARGIN);

  logic signed [MW-1:0] integ_q, integ_d, delta_d, kp, ki, lim;
  logic signed [MW-1:0] p_term, i_step, duty_w;
  logic [DUTY_W-1:0] duty_d;

  always_comb begin
    kp      = samp.ref_large ? MW'(KP_MILD) : MW'(KP_FAST);
    ki      = samp.ref_large ? MW'(KI_MILD) : MW'(KI_FAST);
    lim     = samp.ref_large ? LIM_M : LIM_F;
    i_step  = (samp.err * ki) >>> GSH;
    p_term  = (samp.err * kp) >>> GSH;
    integ_d = pre_en ? pre_val : sat(integ_q + i_step, -lim, lim);
    delta_d = integ_d + p_term;
    duty_w  = sat(samp.ff + delta_d, '0, ONE);
    duty_d  = duty_w[DUTY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      delta_q <= '0;
      duty_q  <= '0;
      mild_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_a;
      if (valid_a) begin
        integ_q <= integ_d;
        delta_q <= delta_d;
        duty_q  <= duty_d;
        mild_q  <= samp.ref_large;
      end
    end
  end

  assert_integ_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_q >= -LIM_M) && (integ_q <= LIM_M));
  assert_fast_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mild_q |-> ((integ_q >= -LIM_F) && (integ_q <= LIM_F)));
  assert_duty_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    MW'(duty_q) <= ONE);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_a |=> ($stable(integ_q) && $stable(duty_q) && $stable(delta_q)));
  assert_preset_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_a && pre_en) |-> samp.big_err);
endmodule

// File: rtl/dtc_pi_sched.sv
module dtc_pi_sched
  import dtc_pkg::*;
#(
  parameter int CW           = 16,
  parameter int FRAC         = 16,
  parameter int GSH          = 8,
  parameter int KP_FAST      = 1573,
  parameter int KI_FAST      = 839,
  parameter int KP_MILD      = 472,
  parameter int KI_MILD      = 42,
  parameter int TD_RATIO     = 10486,
  parameter int AW_MARGIN    = 655,
  parameter int SMALL_PRESET = 5243,
  parameter int BOUND        = 112,
  parameter int ERR_TH       = 32,
  localparam int DUTY_W      = FRAC + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [CW-1:0]     iref,
  input  logic signed [CW-1:0]     imeas,
  input  logic        [DUTY_W-1:0] duty_ff,
  output logic                     duty_valid,
  output logic        [DUTY_W-1:0] duty_reg,
  output logic                     mild_gains
);
  logic [1:0] rst_sync;
  logic       rst_i_n;
  samp_t      samp_q;
  logic       valid_a, pre_en;
  logic signed [MW-1:0] pre_val, delta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  dtc_err_stage #(.CW(CW), .DUTY_W(DUTY_W), .BOUND(BOUND), .ERR_TH(ERR_TH)) u_err (
    .clk(clk), .rst_n(rst_i_n), .smp_valid(smp_valid), .iref(iref), .imeas(imeas),
    .duty_ff(duty_ff), .samp_q(samp_q), .valid_q(valid_a));

  dtc_preset_sel #(.TD_RATIO(TD_RATIO), .SMALL_PRESET(SMALL_PRESET)) u_pre (
    .samp(samp_q), .delta_q(delta_q), .pre_en(pre_en), .pre_val(pre_val));

  dtc_pi_core #(.DUTY_W(DUTY_W), .FRAC(FRAC), .GSH(GSH), .KP_FAST(KP_FAST),
    .KI_FAST(KI_FAST), .KP_MILD(KP_MILD), .KI_MILD(KI_MILD), .TD_RATIO(TD_RATIO),
    .AW_MARGIN(AW_MARGIN)) u_pi (
    .clk(clk), .rst_n(rst_i_n), .valid_a(valid_a), .samp(samp_q), .pre_en(pre_en),
    .pre_val(pre_val), .delta_q(delta_q), .duty_q(duty_reg), .mild_q(mild_gains),
    .valid_q(duty_valid));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    duty_valid |-> $past(smp_valid, 2));
endmodule

// File: tb/test_dtc_pi_sched.sv
module test_dtc_pi_sched;
  localparam int TD = 10486, MG = 655, SP = 5243, BOUND = 112, ETH = 32;
  localparam int ONE = 65536;

  logic clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic signed [15:0] iref = '0, imeas = '0;
  logic [16:0] duty_ff = '0;
  logic duty_valid, mild_gains;
  logic [16:0] duty_reg;

  typedef struct { int duty; bit mild; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  int m_integ = 0, m_delta = 0, last_duty = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dtc_pi_sched i_dtc_pi_sched (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .iref(iref), .imeas(imeas), .duty_ff(duty_ff), .duty_valid(duty_valid),
    .duty_reg(duty_reg), .mild_gains(mild_gains));

  function automatic int clampi(int x, int lo, int hi);
    return (x < lo) ? lo : (x > hi) ? hi : x;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(int r, int m, int ff, string tag);
    int err, lim, kp, ki, pv, acc;
    bit rl, rn, be, pre;
    exp_t e;
    err = r - m;
    rl  = ((r < 0) ? -r : r) >= BOUND;           // R4
    rn  = r < 0;
    be  = ((err < 0) ? -err : err) > ETH;          // R8
    pre = 1'b0; pv = 0;
    if (be && rl && !rn && !(m_delta > TD)) begin pre = 1; pv = TD; end        // R6
    else if (be && rl && rn && !(m_delta < -TD)) begin pre = 1; pv = -TD; end
    else if (be && !rl && (m_delta > TD || m_delta < -TD)) begin             // R7
      pre = 1; pv = rn ? -SP : SP;
    end
    kp  = rl ? 472 : 1573;
    ki  = rl ? 42 : 839;
    lim = rl ? TD + MG : TD;                       // R5
    acc = clampi(m_integ + ((err * ki) >>> 8), -lim, lim);   // R3
    m_integ = pre ? pv : acc;
    m_delta = m_integ + ((err * kp) >>> 8);
    e.duty = clampi(ff + m_delta, 0, ONE);         // R1
    e.mild = rl;
    e.tag  = tag;
    q.push_back(e);
    last_duty = e.duty;
    @(negedge clk);
    iref = 16'(r); imeas = 16'(m); duty_ff = 17'(ff); smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && duty_valid) begin
      if (q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 actual=unexpected output expected=none");
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, int'(duty_reg), e.duty);
        check({e.tag, "/R4"}, int'(mild_gains), int'(e.mild));
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", int'(duty_reg), 0);
    check("R9", int'(mild_gains), 0);
    check("R9", int'(duty_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    apply(0, 0, 49807, "R1");
    apply(64, 0, 49807, "R3");
    apply(64, 32, 49807, "R3");
    apply(480, 0, 49807, "R6");          // large positive step from small state
    for (int i = 0; i < 14; i++) apply(480, 0, 49807, "R5");  // mild ceiling
    // R2: idle window, nothing changes at the ports
    repeat (6) begin
      @(negedge clk);
      check("R2", int'(duty_valid), 0);
      check("R2", int'(duty_reg), last_duty);
    end
    apply(480, 470, 49807, "R8");        // small error, no preset
    apply(-480, 480, 49807, "R6");       // large negative from positive state
    apply(-480, -470, 49807, "R3");
    apply(-16, -480, 49807, "R7");       // back to small, negative preset
    apply(16, -400, 49807, "R7");
    apply(400, 380, 49807, "R8");        // large ref, error 20 -> no preset
    apply(112, 100, 49807, "R4");        // boundary: mild
    apply(111, 100, 49807, "R4");        // just below: fast
    apply(-112, -100, 49807, "R4");
    for (int i = 0; i < 10; i++) apply(80, 0, 49807, "R5"); // fast window
    apply(480, 0, 65500, "R1");          // upper clamp
    apply(-480, 480, 100, "R1");         // lower clamp
    apply(0, 0, 30000, "R1");
    repeat (5) @(negedge clk);
    check("R2", q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule